// File: doc/BRIEF.md
# Data Memory Map with Pointer Redirection

This block is the 64-location byte-wide data space of a small 8-bit controller. The low half holds a set of special registers at fixed addresses: a 6-bit memory pointer, the accumulator, the low byte of the program counter, the table pointer, the table high byte, the status byte and three I/O port latches. The upper half, 20H to 3FH, is 32 bytes of general-purpose storage. Unused addresses in the low half read as zero.

Address 00H has no storage of its own. Any read, write or bit operation aimed at it goes to the location whose address the pointer holds. When the pointer holds 00H, the redirected read returns zero and the redirected write does nothing. A separate bit port sets or clears one bit of any location in one clock. The core drives one combinational read port, one word write port and the bit port. It takes the table high byte from the table logic and receives every other special register as a registered output.

Top module: `dmem_map`

## Requirements
- R1: After reset, every stored location reads 00H. The pointer at 01H reads C0H, and 08H reads the `tblh_i` input.
- R2: The writable registers are 01H (pointer), 05H (accumulator), 06H (PC low), 07H (table pointer), 0AH (status), 12H, 14H and 16H (ports), plus 20H–3FH. A word write takes effect at the next rising clock edge. The read port is combinational.
- R3: The pointer keeps only bits 5..0 of any value written to it. Bits 7..6 of 01H always read as 1.
- R4: Address 00H on any port selects the location whose address is in the pointer.
- R5: When the pointer holds 00H, a read of 00H returns 00H, and a write or bit operation to 00H changes nothing.
- R6: Addresses 02H–04H, 09H, 0BH–11H, 13H, 15H and 17H–1FH read 00H. Writes to them are ignored.
- R7: Address 08H reads `tblh_i`. Writes to 08H are ignored.
- R8: A bit operation with `bit_set`=1 sets, and with 0 clears, bit `bit_idx` of the resolved location in one clock. Bits 7..6 of 01H stay at 1. A bit operation on a read-only or unused location has no effect.
- R9: A read and a write to the same address in the same cycle return the value held before the write.
- R10: If the word write and the bit operation resolve to the same location in one cycle, the word write wins. On different locations, both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_addr | input | 6 | Read address |
| rd_data | output | 8 | Read data, combinational |
| wr_en | input | 1 | Word write enable |
| wr_addr | input | 6 | Word write address |
| wr_data | input | 8 | Word write data |
| bit_en | input | 1 | Bit operation enable |
| bit_addr | input | 6 | Bit operation address |
| bit_idx | input | 3 | Bit index 0..7 |
| bit_set | input | 1 | 1 sets the bit, 0 clears it |
| tblh_i | input | 8 | Table high byte from the table logic |
| acc_o | output | 8 | Accumulator |
| pcl_o | output | 8 | PC low byte |
| tblp_o | output | 8 | Table pointer |
| status_o | output | 8 | Status byte |
| pa_o | output | 8 | Port A latch |
| pb_o | output | 8 | Port B latch |
| pc_o | output | 8 | Port C latch |

## Verification
A wrong pointer value sends every later access to 00H to the wrong location. It shows on the first read of 00H, in the same cycle, because the read path is combinational. A lost or misrouted write shows one clock later, either at the read port or on the register outputs. A redirect that leaks into an unused or read-only location becomes visible only when that address or a neighbour is read back. For that reason the sweeps read every address after each pass of writes.

// File: rtl/dmem_pkg.sv
`timescale 1ns/1ps
package dmem_pkg;
    localparam int unsigned DW = 8;
    localparam int unsigned AW = 6;
    localparam int unsigned PW = 6;

    localparam logic [AW-1:0] A_IND = 6'h00;
    localparam logic [AW-1:0] A_PTR = 6'h01;
    localparam logic [AW-1:0] A_ACC = 6'h05;
    localparam logic [AW-1:0] A_PCL = 6'h06;
    localparam logic [AW-1:0] A_TBP = 6'h07;
    localparam logic [AW-1:0] A_TBH = 6'h08;
    localparam logic [AW-1:0] A_STS = 6'h0A;
    localparam logic [AW-1:0] A_PA  = 6'h12;
    localparam logic [AW-1:0] A_PB  = 6'h14;
    localparam logic [AW-1:0] A_PC  = 6'h16;

    typedef struct packed {
        logic [PW-1:0] ptr;
        logic [DW-1:0] acc;
        logic [DW-1:0] pcl;
        logic [DW-1:0] tbp;
        logic [DW-1:0] sts;
        logic [DW-1:0] pa;
        logic [DW-1:0] pb;
        logic [DW-1:0] pc;
    } sfr_t;
endpackage

// File: rtl/dmem_redirect.sv
`timescale 1ns/1ps
module dmem_redirect
    import dmem_pkg::*;
(
    input  logic [AW-1:0] addr_i,
    input  logic [PW-1:0] ptr_i,
    output logic [AW-1:0] eff_o
);
    // A pointer value of zero resolves to 00H, which has no storage:
    // reads there give zero and writes land nowhere.
    always_comb begin
        eff_o = (addr_i == A_IND) ? AW'(ptr_i) : addr_i;
    end
endmodule

// File: rtl/dmem_gpr.sv
`timescale 1ns/1ps
module dmem_gpr
    import dmem_pkg::*;
#(
    parameter int unsigned DEPTH = 32,
    localparam int unsigned IW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [IW-1:0] ra0,
    output logic [DW-1:0] rd0,
    input  logic [IW-1:0] ra1,
    output logic [DW-1:0] rd1,
    input  logic          we0,
    input  logic [IW-1:0] wa0,
    input  logic [DW-1:0] wd0,
    input  logic          we1,
    input  logic [IW-1:0] wa1,
    input  logic [DW-1:0] wd1
);
    logic [DW-1:0] mem [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        logic [DW-1:0] ent_d, ent_q;

        // Port 1 is applied last so it overrides port 0 on a collision.
        always_comb begin
            ent_d = ent_q;
            if (we0 && wa0 == IW'(i)) ent_d = wd0;
            if (we1 && wa1 == IW'(i)) ent_d = wd1;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ent_q <= '0;
            else        ent_q <= ent_d;
        end

        assign mem[i] = ent_q;
    end

    assign rd0 = mem[ra0];
    assign rd1 = mem[ra1];
endmodule

// File: rtl/dmem_map.sv
`timescale 1ns/1ps
module dmem_map
    import dmem_pkg::*;
#(
    parameter int unsigned GP_BASE  = 32,
    parameter int unsigned GP_DEPTH = 32,
    localparam int unsigned GIW     = $clog2(GP_DEPTH),
    localparam int unsigned GP_END  = GP_BASE + GP_DEPTH,
    localparam int unsigned NPORT   = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [5:0]    rd_addr,
    output logic [7:0]    rd_data,
    input  logic          wr_en,
    input  logic [5:0]    wr_addr,
    input  logic [7:0]    wr_data,
    input  logic          bit_en,
    input  logic [5:0]    bit_addr,
    input  logic [2:0]    bit_idx,
    input  logic          bit_set,
    input  logic [7:0]    tblh_i,
    output logic [7:0]    acc_o,
    output logic [7:0]    pcl_o,
    output logic [7:0]    tblp_o,
    output logic [7:0]    status_o,
    output logic [7:0]    pa_o,
    output logic [7:0]    pb_o,
    output logic [7:0]    pc_o
);
    sfr_t state_d, state_q;

    // Port order: 0 = read, 1 = word write, 2 = bit operation
    logic [AW-1:0] port_addr [NPORT];
    logic [AW-1:0] port_eff  [NPORT];

    assign port_addr[0] = rd_addr;
    assign port_addr[1] = wr_addr;
    assign port_addr[2] = bit_addr;

    for (genvar p = 0; p < NPORT; p++) begin : g_redir
        dmem_redirect i_redir (
            .addr_i (port_addr[p]),
            .ptr_i  (state_q.ptr),
            .eff_o  (port_eff[p])
        );
    end

    function automatic logic in_gp(input logic [AW-1:0] a);
        return (int'(a) >= int'(GP_BASE)) && (int'(a) < int'(GP_END));
    endfunction

    function automatic logic [GIW-1:0] gp_idx(input logic [AW-1:0] a);
        return GIW'(int'(a) - int'(GP_BASE));
    endfunction

    function automatic logic [DW-1:0] sfr_read(input sfr_t s, input logic [AW-1:0] a,
                                               input logic [DW-1:0] tbh);
        case (a)
            A_PTR:   return {2'b11, s.ptr};
            A_ACC:   return s.acc;
            A_PCL:   return s.pcl;
            A_TBP:   return s.tbp;
            A_TBH:   return tbh;
            A_STS:   return s.sts;
            A_PA:    return s.pa;
            A_PB:    return s.pb;
            A_PC:    return s.pc;
            default: return '0;
        endcase
    endfunction

    function automatic sfr_t sfr_write(input sfr_t s, input logic [AW-1:0] a,
                                       input logic [DW-1:0] d);
        sfr_t r;
        r = s;
        case (a)
            A_PTR:   r.ptr = d[PW-1:0];
            A_ACC:   r.acc = d;
            A_PCL:   r.pcl = d;
            A_TBP:   r.tbp = d;
            A_STS:   r.sts = d;
            A_PA:    r.pa  = d;
            A_PB:    r.pb  = d;
            A_PC:    r.pc  = d;
            default: r = s;
        endcase
        return r;
    endfunction

    logic [DW-1:0] gp_rd, gp_bit;
    logic [DW-1:0] bit_old, bit_new, bit_mask;
    logic          gp_we_bit, gp_we_wr;

    dmem_gpr #(.DEPTH(GP_DEPTH)) i_gpr (
        .clk   (clk),
        .rst_n (rst_n),
        .ra0   (gp_idx(port_eff[0])),
        .rd0   (gp_rd),
        .ra1   (gp_idx(port_eff[2])),
        .rd1   (gp_bit),
        .we0   (gp_we_bit),
        .wa0   (gp_idx(port_eff[2])),
        .wd0   (bit_new),
        .we1   (gp_we_wr),
        .wa1   (gp_idx(port_eff[1])),
        .wd1   (wr_data)
    );

    always_comb begin
        rd_data   = in_gp(port_eff[0]) ? gp_rd  : sfr_read(state_q, port_eff[0], tblh_i);
        bit_old   = in_gp(port_eff[2]) ? gp_bit : sfr_read(state_q, port_eff[2], tblh_i);
        bit_mask  = DW'(1) << bit_idx;
        bit_new   = bit_set ? (bit_old | bit_mask) : (bit_old & ~bit_mask);
        gp_we_bit = bit_en && in_gp(port_eff[2]);
        gp_we_wr  = wr_en  && in_gp(port_eff[1]);

        // Bit operation first, word write second: the word write wins.
        state_d = state_q;
        if (bit_en) state_d = sfr_write(state_d, port_eff[2], bit_new);
        if (wr_en)  state_d = sfr_write(state_d, port_eff[1], wr_data);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    logic [PW-1:0] ptr_now;
    assign ptr_now  = state_q.ptr;
    assign acc_o    = state_q.acc;
    assign pcl_o    = state_q.pcl;
    assign tblp_o   = state_q.tbp;
    assign status_o = state_q.sts;
    assign pa_o     = state_q.pa;
    assign pb_o     = state_q.pb;
    assign pc_o     = state_q.pc;
endmodule

// File: rtl/dmem_map_chk.sv
`timescale 1ns/1ps
module dmem_map_chk
    import dmem_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic [5:0] rd_addr,
    input logic [7:0] rd_data,
    input logic       wr_en,
    input logic [5:0] wr_addr,
    input logic [7:0] wr_data,
    input logic       bit_en,
    input logic [5:0] bit_addr,
    input logic [2:0] bit_idx,
    input logic       bit_set,
    input logic [7:0] acc_o,
    input logic [7:0] pcl_o,
    input logic [7:0] pa_o,
    input logic [5:0] ptr
);
    assert_ptr_top_ones_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_addr == A_PTR |-> rd_data[7:6] == 2'b11);

    assert_ptr_low_bits_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_PTR && !bit_en) |=> ptr == $past(wr_data[5:0]));

    assert_redirect_acc_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == A_IND && ptr == A_ACC) |-> rd_data == acc_o);

    assert_null_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == A_IND && ptr == 6'h00) |-> rd_data == 8'h00);

    assert_unused_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr inside {6'h02, 6'h03, 6'h04, 6'h09, [6'h0B:6'h11], 6'h13, 6'h15, [6'h17:6'h1F]})
        |-> rd_data == 8'h00);

    assert_acc_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_ACC) |=> acc_o == $past(wr_data));

    assert_tbh_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_TBH && !bit_en) |=>
        ($stable(acc_o) && $stable(pcl_o) && $stable(pa_o) && $stable(ptr)));

    assert_bitop_acc_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && bit_addr == A_ACC && !wr_en) |=>
        acc_o == ($past(bit_set) ? ($past(acc_o) | (8'h01 << $past(bit_idx)))
                                 : ($past(acc_o) & ~(8'h01 << $past(bit_idx)))));

    assert_word_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && bit_en && wr_addr == A_PCL && bit_addr == A_PCL) |=> pcl_o == $past(wr_data));
endmodule

bind dmem_map dmem_map_chk i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .bit_en   (bit_en),
    .bit_addr (bit_addr),
    .bit_idx  (bit_idx),
    .bit_set  (bit_set),
    .acc_o    (acc_o),
    .pcl_o    (pcl_o),
    .pa_o     (pa_o),
    .ptr      (ptr_now)
);

// File: tb/test_dmem_map.sv
`timescale 1ns/1ps
module test_dmem_map;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       wr_en = 1'b0;
    logic [5:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       bit_en = 1'b0;
    logic [5:0] bit_addr = '0;
    logic [2:0] bit_idx = '0;
    logic       bit_set = 1'b0;
    logic [7:0] tblh_i = 8'hA5;
    logic [7:0] acc_o, pcl_o, tblp_o, status_o, pa_o, pb_o, pc_o;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    dmem_map i_dmem_map (
        .clk(clk), .rst_n(rst_n),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .bit_en(bit_en), .bit_addr(bit_addr), .bit_idx(bit_idx), .bit_set(bit_set),
        .tblh_i(tblh_i),
        .acc_o(acc_o), .pcl_o(pcl_o), .tblp_o(tblp_o), .status_o(status_o),
        .pa_o(pa_o), .pb_o(pb_o), .pc_o(pc_o)
    );

    // Expected contents, derived from the requirements
    logic [7:0] mdl [64];
    logic [5:0] mptr;

    function automatic logic writable(input logic [5:0] a);
        return (a >= 6'h20) || (a inside {6'h05, 6'h06, 6'h07, 6'h0A, 6'h12, 6'h14, 6'h16});
    endfunction

    function automatic logic [5:0] resolve(input logic [5:0] a);
        return (a == 6'h00) ? mptr : a;
    endfunction

    function automatic logic [7:0] m_read(input logic [5:0] a);
        logic [5:0] e;
        e = resolve(a);
        if (e == 6'h01) return {2'b11, mptr};
        if (e == 6'h08) return tblh_i;
        if (writable(e)) return mdl[e];
        return 8'h00;
    endfunction

    function automatic string tag_of(input logic [5:0] a);
        if (a == 6'h00) return "R4";
        if (a == 6'h01) return "R3";
        if (a == 6'h08) return "R7";
        if (writable(a)) return "R2";
        return "R6";
    endfunction

    task automatic m_store(input logic [5:0] e, input logic [7:0] d);
        if (e == 6'h01) mptr = d[5:0];
        else if (writable(e)) mdl[e] = d;
    endtask

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic rd_check(input logic [5:0] a, input string req);
        @(negedge clk);
        rd_addr = a;
        #1;
        check(req, rd_data, m_read(a));
    endtask

    // One clock with optional word write and bit operation
    task automatic op(input logic we, input logic [5:0] wa, input logic [7:0] wd,
                      input logic be, input logic [5:0] ba, input logic [2:0] bi,
                      input logic bs);
        logic [5:0] eb, ew;
        logic [7:0] nb;
        @(negedge clk);
        wr_en = we; wr_addr = wa; wr_data = wd;
        bit_en = be; bit_addr = ba; bit_idx = bi; bit_set = bs;
        eb = resolve(ba);
        ew = resolve(wa);
        nb = bs ? (m_read(ba) | (8'h01 << bi)) : (m_read(ba) & ~(8'h01 << bi));
        @(posedge clk);
        if (be && eb != 6'h00) m_store(eb, nb);
        if (we && ew != 6'h00) m_store(ew, wd);
        #1;
        wr_en = 1'b0;
        bit_en = 1'b0;
    endtask

    task automatic out_check(input string req);
        @(negedge clk);
        check(req, acc_o, mdl[6'h05]);
        check(req, pcl_o, mdl[6'h06]);
        check(req, tblp_o, mdl[6'h07]);
        check(req, status_o, mdl[6'h0A]);
        check(req, pa_o, mdl[6'h12]);
        check(req, pb_o, mdl[6'h14]);
        check(req, pc_o, mdl[6'h16]);
    endtask

    task automatic sweep_read();
        for (int a = 0; a < 64; a++) rd_check(6'(a), tag_of(6'(a)));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int a = 0; a < 64; a++) mdl[a] = 8'h00;
        mptr = 6'h00;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state across the whole map
        for (int a = 0; a < 64; a++) rd_check(6'(a), "R1");
        out_check("R1");

        // R2, R3, R5, R6, R7: direct write of every address, then read back
        for (int a = 0; a < 64; a++) op(1'b1, 6'(a), 8'((a * 37 + 11) ^ 8'hC3), 1'b0, 6'h00, 3'd0, 1'b0);
        sweep_read();
        out_check("R2");

        // R4, R5: redirect through 00H to each target
        for (int t = 0; t < 64; t++) begin
            op(1'b1, 6'h01, 8'(t) | 8'hC0, 1'b0, 6'h00, 3'd0, 1'b0);
            rd_check(6'h00, (t == 0) ? "R5" : "R4");
            op(1'b1, 6'h00, 8'(t) ^ 8'h5A, 1'b0, 6'h00, 3'd0, 1'b0);
            rd_check(6'h00, (t == 0) ? "R5" : "R4");
            rd_check(6'(t), (t == 0) ? "R5" : "R4");
        end
        sweep_read();

        // R8: set then clear one bit of every address, directly
        for (int a = 0; a < 64; a++) begin
            op(1'b0, 6'h00, 8'h00, 1'b1, 6'(a), 3'(a), 1'b1);
            rd_check(6'(a), "R8");
            op(1'b0, 6'h00, 8'h00, 1'b1, 6'(a), 3'(a + 3), 1'b0);
            rd_check(6'(a), "R8");
        end
        // R8: fixed pointer bits, and bit operations through 00H
        op(1'b1, 6'h01, 8'h2A, 1'b0, 6'h00, 3'd0, 1'b0);
        op(1'b0, 6'h00, 8'h00, 1'b1, 6'h01, 3'd7, 1'b0);
        rd_check(6'h01, "R8");
        for (int i = 0; i < 8; i++) begin
            op(1'b0, 6'h00, 8'h00, 1'b1, 6'h00, 3'(i), (i % 2) == 0);
            rd_check(6'h2A, "R8");
        end
        op(1'b1, 6'h01, 8'h00, 1'b0, 6'h00, 3'd0, 1'b0);
        op(1'b0, 6'h00, 8'h00, 1'b1, 6'h00, 3'd4, 1'b1);
        sweep_read();
        out_check("R8");

        // R9: same-cycle read and write return the old value
        @(negedge clk);
        rd_addr = 6'h25;
        wr_en = 1'b1; wr_addr = 6'h25; wr_data = 8'h9E;
        #1 check("R9", rd_data, mdl[6'h25]);
        @(posedge clk);
        mdl[6'h25] = 8'h9E;
        #1 wr_en = 1'b0;
        rd_check(6'h25, "R9");

        // R10: collision on the same location, then on different locations
        op(1'b1, 6'h30, 8'h11, 1'b1, 6'h30, 3'd7, 1'b1);
        rd_check(6'h30, "R10");
        check("R10", rd_data, 8'h11);
        op(1'b1, 6'h06, 8'h44, 1'b1, 6'h06, 3'd0, 1'b1);
        out_check("R10");
        check("R10", pcl_o, 8'h44);
        op(1'b1, 6'h31, 8'h66, 1'b1, 6'h05, 3'd1, 1'b1);
        rd_check(6'h31, "R10");
        out_check("R10");

        // R7: table high byte follows the input
        tblh_i = 8'h3C;
        rd_check(6'h08, "R7");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule